// File: doc/BRIEF.md
# Clock Stop Gating with Free-Running Copies

This block sits between the clock sources of a board-level clock generator and its output pads. It takes four source clocks (processor, peripheral bus, memory buffer input and crystal reference). From them it produces gated copies and one free-running copy per source. Two active-low stop requests control the gating. The global stop parks the processor, memory and interrupt-controller clocks. The bus stop parks only the gated peripheral-bus clocks. Each output also has a run bit, held in a configuration register elsewhere, that forces it low. A two-bit output mode can release every pad into high impedance through a common output enable.

Gating never shortens a pulse. Each domain synchronizes its stop request on its own clock, and an enable register updates on the falling edge. A latch that is transparent only while the clock is low then holds that enable. The gated output is the source clock ANDed with the held enable. It therefore starts and stops only on whole cycles and parks low. The global stop passes through two synchronizer stages. The bus stop is captured once, on the rising edge of the free-running bus clock.

Top module: `clk_stop_gate`

## Requirements
- R1: After clk_stop_n falls between two rising edges of cpu_clk, cpu_o still delivers the pulses of the next two rising edges of cpu_clk and is low from the third on.
- R2: After clk_stop_n returns high between two rising edges of cpu_clk, cpu_o stays low for the next two rising edges and pulses again from the third. Every high pulse on every clock output lasts exactly the high phase of its source clock.
- R3: cpu_free_o, pci_free_o, sdr_free_o and ref_free_o keep toggling whatever the levels of clk_stop_n and pci_stop_n.
- R4: pci_stop_n is captured on each rising edge of pci_clk. The pci_o pulse of the capturing edge is still delivered and the change takes effect from the following edge, both for stop and for release.
- R5: pci_stop_n has no effect on cpu_o, sdr_o or apic_o, and clk_stop_n has no effect on pci_o.
- R6: While clk_stop_n is low, sdr_o and apic_o are parked low after their synchronizer latency, and they resume when it returns high.
- R7: Each run vector holds one bit per gated output at that output's index, plus the free-running copy at the top index (N). A bit of 0 holds its output low from the next falling edge of its clock, and a bit of 1 lets it run.
- R8: oe_o is low exactly when mode_i is 2'b11. Codes 00, 01 and 10 keep it high, and the mode does not alter the clock outputs.
- R9: While rst is high, every clock output is low, and oe_o follows mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled in every clock domain |
| cpu_clk | input | 1 | Processor-rate source clock |
| pci_clk | input | 1 | Peripheral-bus source clock |
| sdr_clk | input | 1 | Memory buffer input clock |
| ref_clk | input | 1 | Crystal reference clock |
| clk_stop_n | input | 1 | Global stop request, active low |
| pci_stop_n | input | 1 | Peripheral-bus stop request, active low |
| mode_i | input | 2 | Output mode; 11 floats all pads |
| cpu_run_i | input | CPU_N+1 | Run bits: gated processor clocks, top bit free copy |
| pci_run_i | input | PCI_N+1 | Run bits: gated bus clocks, top bit free copy |
| sdr_run_i | input | SDR_N+1 | Run bits: gated memory clocks, top bit free copy |
| ref_run_i | input | APIC_N+1 | Run bits: interrupt-controller clocks, top bit free reference |
| cpu_free_o | output | 1 | Processor clock exempt from stops |
| cpu_o | output | CPU_N | Gated processor clocks |
| pci_free_o | output | 1 | Bus clock exempt from stops |
| pci_o | output | PCI_N | Gated bus clocks |
| sdr_free_o | output | 1 | Memory clock exempt from stops |
| sdr_o | output | SDR_N | Gated memory clocks |
| ref_free_o | output | 1 | Reference clock exempt from stops |
| apic_o | output | APIC_N | Interrupt-controller clocks stopped by the global stop |
| oe_o | output | 1 | Common pad output enable |

## Verification
The bench counts the gated pulses edge by edge around each stop and release. A design that samples the request too early or too late shows up as one pulse too many or too few, and an enable taken on the rising edge shows up as a clipped first or last pulse. Every output has a monitor that measures each high time, so any runt or stretched pulse during stops, run-bit changes and mode changes is counted. The bench also drives a stop in each domain and watches the other domain. A design that crossed the two stop inputs, or gated a free-running copy, would stop clocks that must keep running. Run-bit patterns are walked across all four mode codes, and a design that let the float mode reach the gating would stop clocks there.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

    // default output counts per clock class
    localparam int CPU_OUTS  = 1;
    localparam int PCI_OUTS  = 5;
    localparam int SDR_OUTS  = 12;
    localparam int APIC_OUTS = 1;

    // synchronizer depth per stop domain
    localparam int CPU_SYNC_STAGES = 2;
    localparam int PCI_SYNC_STAGES = 1;

    typedef enum logic [1:0] {
        OM_RUN    = 2'b00,
        OM_RSVD   = 2'b01,
        OM_SPREAD = 2'b10,
        OM_FLOAT  = 2'b11
    } out_mode_e;

    // gating request seen by one output cell
    typedef struct packed {
        logic run;    // per-output run bit
        logic allow;  // synchronized stop permission
    } gate_req_t;

    function automatic logic pads_driven(input logic [1:0] m);
        return out_mode_e'(m) != OM_FLOAT;
    endfunction

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= RST_VAL;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= {STAGES{RST_VAL}};
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
module cg_gate_cell
    import clkgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_req_t req,
    output logic      gclk
);
    logic en_q;
    logic en_l;

    // enable moves only while the clock is low
    always_ff @(negedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= req.run & req.allow;
    end

    // hold the enable through the whole high phase
    always_latch begin
        if (!clk) en_l = en_q;
    end

    assign gclk = clk & en_l;
endmodule

// File: rtl/cg_domain.sv
`timescale 1ns/1ps
module cg_domain
    import clkgate_pkg::*;
#(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stop_n,
    input  logic [N:0]   run_i,
    output logic         free_o,
    output logic [N-1:0] gated_o
);
    localparam int CELLS = N + 1;

    logic      allow;
    gate_req_t req [CELLS];

    cg_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (stop_n),
        .q   (allow)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_cell
            assign req[g] = '{run: run_i[g], allow: allow};
            cg_gate_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .req  (req[g]),
                .gclk (gated_o[g])
            );
        end
    endgenerate

    // free copy ignores the stop request
    assign req[N] = '{run: run_i[N], allow: 1'b1};
    cg_gate_cell u_free (
        .clk  (clk),
        .rst  (rst),
        .req  (req[N]),
        .gclk (free_o)
    );
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
    import clkgate_pkg::*;
#(
    parameter int CPU_N    = CPU_OUTS,
    parameter int PCI_N    = PCI_OUTS,
    parameter int SDR_N    = SDR_OUTS,
    parameter int APIC_N   = APIC_OUTS,
    parameter int CPU_SYNC = CPU_SYNC_STAGES,
    parameter int PCI_SYNC = PCI_SYNC_STAGES
) (
    input  logic              rst,
    input  logic              cpu_clk,
    input  logic              pci_clk,
    input  logic              sdr_clk,
    input  logic              ref_clk,
    input  logic              clk_stop_n,
    input  logic              pci_stop_n,
    input  logic [1:0]        mode_i,
    input  logic [CPU_N:0]    cpu_run_i,
    input  logic [PCI_N:0]    pci_run_i,
    input  logic [SDR_N:0]    sdr_run_i,
    input  logic [APIC_N:0]   ref_run_i,
    output logic              cpu_free_o,
    output logic [CPU_N-1:0]  cpu_o,
    output logic              pci_free_o,
    output logic [PCI_N-1:0]  pci_o,
    output logic              sdr_free_o,
    output logic [SDR_N-1:0]  sdr_o,
    output logic              ref_free_o,
    output logic [APIC_N-1:0] apic_o,
    output logic              oe_o
);
    // processor clocks: global stop
    cg_domain #(.N(CPU_N), .STAGES(CPU_SYNC)) u_cpu (
        .clk (cpu_clk), .rst (rst), .stop_n (clk_stop_n),
        .run_i (cpu_run_i), .free_o (cpu_free_o), .gated_o (cpu_o)
    );

    // bus clocks: bus stop, captured on the bus clock
    cg_domain #(.N(PCI_N), .STAGES(PCI_SYNC)) u_pci (
        .clk (pci_clk), .rst (rst), .stop_n (pci_stop_n),
        .run_i (pci_run_i), .free_o (pci_free_o), .gated_o (pci_o)
    );

    // memory buffer clocks: global stop
    cg_domain #(.N(SDR_N), .STAGES(CPU_SYNC)) u_sdr (
        .clk (sdr_clk), .rst (rst), .stop_n (clk_stop_n),
        .run_i (sdr_run_i), .free_o (sdr_free_o), .gated_o (sdr_o)
    );

    // reference clocks: interrupt-controller copies obey the global stop
    cg_domain #(.N(APIC_N), .STAGES(CPU_SYNC)) u_ref (
        .clk (ref_clk), .rst (rst), .stop_n (clk_stop_n),
        .run_i (ref_run_i), .free_o (ref_free_o), .gated_o (apic_o)
    );

    assign oe_o = pads_driven(mode_i);
endmodule

// File: rtl/cg_checker.sv
`timescale 1ns/1ps
module cg_checker #(
    parameter int CPU_N    = 1,
    parameter int PCI_N    = 5,
    parameter int SDR_N    = 12,
    parameter int APIC_N   = 1,
    parameter int CPU_SYNC = 2,
    parameter int PCI_SYNC = 1
) (
    input logic              rst,
    input logic              cpu_clk,
    input logic              pci_clk,
    input logic              sdr_clk,
    input logic              ref_clk,
    input logic              clk_stop_n,
    input logic              pci_stop_n,
    input logic [1:0]        mode_i,
    input logic [CPU_N:0]    cpu_run_i,
    input logic [PCI_N:0]    pci_run_i,
    input logic              cpu_free_o,
    input logic [CPU_N-1:0]  cpu_o,
    input logic              pci_free_o,
    input logic [PCI_N-1:0]  pci_o,
    input logic [SDR_N-1:0]  sdr_o,
    input logic [APIC_N-1:0] apic_o,
    input logic              oe_o
);
    // R2: a gated or free output only changes together with its source clock
    always @(cpu_o or cpu_free_o) begin
        if (!rst) begin
            a_r2_cpu_edge_aligned: assert (({cpu_free_o, cpu_o} & ~{(CPU_N+1){cpu_clk}}) == '0);
        end
    end

    always @(pci_o or pci_free_o) begin
        if (!rst) begin
            a_r2_pci_edge_aligned: assert (({pci_free_o, pci_o} & ~{(PCI_N+1){pci_clk}}) == '0);
        end
    end

    generate
        if (CPU_SYNC == 2) begin : g_cpu_lat
            // R1: parked low once the stop has crossed both stages
            a_r1_cpu_parked: assert property (@(negedge cpu_clk) disable iff (rst)
                (!clk_stop_n && !$past(clk_stop_n) && !$past(clk_stop_n, 2) && !$past(clk_stop_n, 3))
                |-> (cpu_o == '0));
            // R6: memory and interrupt-controller clocks park too
            a_r6_sdr_parked: assert property (@(negedge sdr_clk) disable iff (rst)
                (!clk_stop_n && !$past(clk_stop_n) && !$past(clk_stop_n, 2) && !$past(clk_stop_n, 3))
                |-> (sdr_o == '0));
            a_r6_apic_parked: assert property (@(negedge ref_clk) disable iff (rst)
                (!clk_stop_n && !$past(clk_stop_n) && !$past(clk_stop_n, 2) && !$past(clk_stop_n, 3))
                |-> (apic_o == '0));
        end
        if (PCI_SYNC == 1) begin : g_pci_lat
            // R4: one capture edge, then parked
            a_r4_pci_parked: assert property (@(negedge pci_clk) disable iff (rst)
                (!pci_stop_n && !$past(pci_stop_n) && !$past(pci_stop_n, 2))
                |-> (pci_o == '0));
        end
    endgenerate

    // R3: free copies keep running with their run bit set
    a_r3_cpu_free_runs: assert property (@(negedge cpu_clk) disable iff (rst)
        (!$past(rst) && cpu_run_i[CPU_N] && $past(cpu_run_i[CPU_N])) |-> cpu_free_o);
    a_r3_pci_free_runs: assert property (@(negedge pci_clk) disable iff (rst)
        (!$past(rst) && pci_run_i[PCI_N] && $past(pci_run_i[PCI_N])) |-> pci_free_o);

    // R7: a cleared run bit holds its output low
    generate
        for (genvar i = 0; i < PCI_N; i++) begin : g_run
            a_r7_pci_run_low: assert property (@(negedge pci_clk) disable iff (rst)
                (!pci_run_i[i] && !$past(pci_run_i[i])) |-> !pci_o[i]);
        end
    endgenerate

    // R8: float code releases the pads
    a_r8_float_off: assert property (@(posedge cpu_clk) disable iff (rst)
        (mode_i == 2'b11) |-> !oe_o);
endmodule

bind clk_stop_gate cg_checker #(
    .CPU_N (CPU_N), .PCI_N (PCI_N), .SDR_N (SDR_N), .APIC_N (APIC_N),
    .CPU_SYNC (CPU_SYNC), .PCI_SYNC (PCI_SYNC)
) u_chk (
    .rst (rst), .cpu_clk (cpu_clk), .pci_clk (pci_clk), .sdr_clk (sdr_clk),
    .ref_clk (ref_clk), .clk_stop_n (clk_stop_n), .pci_stop_n (pci_stop_n),
    .mode_i (mode_i), .cpu_run_i (cpu_run_i), .pci_run_i (pci_run_i),
    .cpu_free_o (cpu_free_o), .cpu_o (cpu_o), .pci_free_o (pci_free_o),
    .pci_o (pci_o), .sdr_o (sdr_o), .apic_o (apic_o), .oe_o (oe_o)
);

// File: tb/sim_clk_stop_gate.sv
`timescale 1ns/1ps
module sim_pulse_mon #(
    parameter real HALF_NS = 5.0
) (
    input  logic        sig,
    output logic [31:0] rises_o,
    output logic [31:0] runts_o
);
    int unsigned n_r  = 0;
    int unsigned n_rt = 0;
    realtime     t_up = 0.0;

    always @(posedge sig) begin
        n_r++;
        t_up = $realtime;
    end

    always @(negedge sig) begin
        if (($realtime - t_up) < (HALF_NS - 0.01) || ($realtime - t_up) > (HALF_NS + 0.01))
            n_rt++;
    end

    assign rises_o = n_r;
    assign runts_o = n_rt;
endmodule

module sim_clk_stop_gate;
    import clkgate_pkg::*;

    localparam int CPU_N  = CPU_OUTS;
    localparam int PCI_N  = PCI_OUTS;
    localparam int SDR_N  = SDR_OUTS;
    localparam int APIC_N = APIC_OUTS;

    // {mode[1:0], pci_run[5:0], expected oe}
    localparam logic [8:0] VEC [6] = '{
        9'b00_111111_1,
        9'b01_101010_1,
        9'b10_010101_1,
        9'b11_111111_0,
        9'b11_000110_0,
        9'b00_100001_1
    };

    logic rst = 1'b1;
    logic cpu_clk = 1'b0, pci_clk = 1'b0, sdr_clk = 1'b0, ref_clk = 1'b0;
    logic clk_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic [1:0]        mode_i = 2'b00;
    logic [CPU_N:0]    cpu_run_i = '1;
    logic [PCI_N:0]    pci_run_i = '1;
    logic [SDR_N:0]    sdr_run_i = '1;
    logic [APIC_N:0]   ref_run_i = '1;
    logic              cpu_free_o, pci_free_o, sdr_free_o, ref_free_o, oe_o;
    logic [CPU_N-1:0]  cpu_o;
    logic [PCI_N-1:0]  pci_o;
    logic [SDR_N-1:0]  sdr_o;
    logic [APIC_N-1:0] apic_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // 100 MHz main clock; others offset so no edge lands on a drive time
    always #5 cpu_clk = ~cpu_clk;
    always #15 pci_clk = ~pci_clk;
    always #35 ref_clk = ~ref_clk;
    initial begin
        #3;
        forever #5 sdr_clk = ~sdr_clk;
    end

    clk_stop_gate u0 (
        .rst (rst), .cpu_clk (cpu_clk), .pci_clk (pci_clk), .sdr_clk (sdr_clk),
        .ref_clk (ref_clk), .clk_stop_n (clk_stop_n), .pci_stop_n (pci_stop_n),
        .mode_i (mode_i), .cpu_run_i (cpu_run_i), .pci_run_i (pci_run_i),
        .sdr_run_i (sdr_run_i), .ref_run_i (ref_run_i),
        .cpu_free_o (cpu_free_o), .cpu_o (cpu_o), .pci_free_o (pci_free_o),
        .pci_o (pci_o), .sdr_free_o (sdr_free_o), .sdr_o (sdr_o),
        .ref_free_o (ref_free_o), .apic_o (apic_o), .oe_o (oe_o)
    );

    // pulse monitors; top index of each array is the free copy
    logic [31:0] cpu_r [CPU_N+1], cpu_rt [CPU_N+1];
    logic [31:0] pci_r [PCI_N+1], pci_rt [PCI_N+1];
    logic [31:0] sdr_r [SDR_N+1], sdr_rt [SDR_N+1];
    logic [31:0] ref_r [APIC_N+1], ref_rt [APIC_N+1];

    generate
        for (genvar g = 0; g < CPU_N; g++) begin : g_mc
            sim_pulse_mon #(.HALF_NS(5.0)) m (.sig(cpu_o[g]), .rises_o(cpu_r[g]), .runts_o(cpu_rt[g]));
        end
        for (genvar g = 0; g < PCI_N; g++) begin : g_mp
            sim_pulse_mon #(.HALF_NS(15.0)) m (.sig(pci_o[g]), .rises_o(pci_r[g]), .runts_o(pci_rt[g]));
        end
        for (genvar g = 0; g < SDR_N; g++) begin : g_ms
            sim_pulse_mon #(.HALF_NS(5.0)) m (.sig(sdr_o[g]), .rises_o(sdr_r[g]), .runts_o(sdr_rt[g]));
        end
        for (genvar g = 0; g < APIC_N; g++) begin : g_ma
            sim_pulse_mon #(.HALF_NS(35.0)) m (.sig(apic_o[g]), .rises_o(ref_r[g]), .runts_o(ref_rt[g]));
        end
    endgenerate
    sim_pulse_mon #(.HALF_NS(5.0))  m_cf (.sig(cpu_free_o), .rises_o(cpu_r[CPU_N]),  .runts_o(cpu_rt[CPU_N]));
    sim_pulse_mon #(.HALF_NS(15.0)) m_pf (.sig(pci_free_o), .rises_o(pci_r[PCI_N]),  .runts_o(pci_rt[PCI_N]));
    sim_pulse_mon #(.HALF_NS(5.0))  m_sf (.sig(sdr_free_o), .rises_o(sdr_r[SDR_N]),  .runts_o(sdr_rt[SDR_N]));
    sim_pulse_mon #(.HALF_NS(35.0)) m_rf (.sig(ref_free_o), .rises_o(ref_r[APIC_N]), .runts_o(ref_rt[APIC_N]));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cpu(input int n);
        repeat (n) @(posedge cpu_clk);
        #2;
    endtask

    task automatic wait_pci(input int n);
        repeat (n) @(posedge pci_clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int base [PCI_N+1];
        int c0, s0, a0, p0, f0, f1, f2, f3, q0;
        int runts;

        // R9: reset state
        wait_cpu(20);
        chk("R9 outputs low in reset", int'({cpu_free_o, cpu_o, pci_free_o, pci_o,
                                              sdr_free_o, sdr_o, ref_free_o, apic_o} != '0), 0);
        chk("R9 oe follows mode in reset", int'(oe_o), 1);
        rst = 1'b0;
        wait_cpu(20);

        // R7 / R8: run-bit patterns under each mode code
        for (int k = 0; k < 6; k++) begin
            @(posedge pci_clk); #2;
            mode_i    = VEC[k][8:7];
            pci_run_i = VEC[k][6:1];
            wait_pci(3);
            for (int j = 0; j <= PCI_N; j++) base[j] = int'(pci_r[j]);
            wait_pci(4);
            chk("R8 oe for mode code", int'(oe_o), int'(VEC[k][0]));
            for (int j = 0; j <= PCI_N; j++)
                chk("R7 pci run bit pulses", int'(int'(pci_r[j]) - base[j] > 0), int'(VEC[k][1+j]));
        end
        mode_i    = 2'b00;
        pci_run_i = '1;
        wait_cpu(5);

        // R1: global stop latency
        c0 = int'(cpu_r[0]);
        clk_stop_n = 1'b0;
        wait_cpu(2);
        chk("R1 pulses before stop takes hold", int'(cpu_r[0]) - c0, 2);
        wait_cpu(1);
        chk("R1 third edge suppressed", int'(cpu_r[0]) - c0, 2);
        wait_cpu(30);
        s0 = int'(sdr_r[0]); a0 = int'(ref_r[0]); p0 = int'(pci_r[0]);
        f0 = int'(cpu_r[CPU_N]); f1 = int'(pci_r[PCI_N]);
        f2 = int'(sdr_r[SDR_N]); f3 = int'(ref_r[APIC_N]);
        c0 = int'(cpu_r[0]);
        wait_cpu(30);
        chk("R1 cpu parked low", int'(cpu_o != '0), 0);
        chk("R1 no cpu pulses while stopped", int'(cpu_r[0]) - c0, 0);
        chk("R6 sdr parked", int'(sdr_r[0]) - s0, 0);
        chk("R6 apic parked", int'(ref_r[0]) - a0, 0);
        chk("R5 pci ignores global stop", int'(int'(pci_r[0]) - p0 > 0), 1);
        chk("R3 cpu free runs", int'(cpu_r[CPU_N]) - f0, 30);
        chk("R3 pci free runs", int'(int'(pci_r[PCI_N]) - f1 > 0), 1);
        chk("R3 sdr free runs", int'(sdr_r[SDR_N]) - f2, 30);
        chk("R3 ref free runs", int'(int'(ref_r[APIC_N]) - f3 > 0), 1);

        // R2: restart on whole cycles
        c0 = int'(cpu_r[0]);
        clk_stop_n = 1'b1;
        wait_cpu(2);
        chk("R2 still low two edges after release", int'(cpu_r[0]) - c0, 0);
        wait_cpu(1);
        chk("R2 first pulse on third edge", int'(cpu_r[0]) - c0, 1);
        wait_cpu(40);
        s0 = int'(sdr_r[0]); a0 = int'(ref_r[0]);
        wait_cpu(30);
        chk("R6 sdr resumes", int'(int'(sdr_r[0]) - s0 > 0), 1);
        chk("R6 apic resumes", int'(int'(ref_r[0]) - a0 > 0), 1);

        // R4: bus stop captured on the bus clock
        wait_pci(2);
        q0 = int'(pci_r[0]);
        pci_stop_n = 1'b0;
        wait_pci(1);
        chk("R4 capturing edge still pulses", int'(pci_r[0]) - q0, 1);
        wait_pci(1);
        chk("R4 next edge suppressed", int'(pci_r[0]) - q0, 1);
        for (int j = 0; j <= PCI_N; j++) base[j] = int'(pci_r[j]);
        c0 = int'(cpu_r[0]); s0 = int'(sdr_r[0]);
        wait_pci(5);
        for (int j = 0; j < PCI_N; j++)
            chk("R4 gated pci parked", int'(pci_r[j]) - base[j], 0);
        chk("R3 pci free ignores bus stop", int'(pci_r[PCI_N]) - base[PCI_N], 5);
        chk("R5 cpu ignores bus stop", int'(cpu_r[0]) - c0, 15);
        chk("R5 sdr ignores bus stop", int'(int'(sdr_r[0]) - s0 > 0), 1);
        q0 = int'(pci_r[0]);
        pci_stop_n = 1'b1;
        wait_pci(1);
        chk("R4 release edge still low", int'(pci_r[0]) - q0, 0);
        wait_pci(1);
        chk("R4 restart on following edge", int'(pci_r[0]) - q0, 1);

        // R7: run bit on a free copy during a global stop
        wait_cpu(2);
        clk_stop_n = 1'b0;
        cpu_run_i[CPU_N] = 1'b0;
        wait_cpu(3);
        f0 = int'(cpu_r[CPU_N]);
        wait_cpu(5);
        chk("R7 free copy held by run bit", int'(cpu_r[CPU_N]) - f0, 0);
        chk("R7 free copy parked low", int'(cpu_free_o), 0);
        cpu_run_i[CPU_N] = 1'b1;
        clk_stop_n = 1'b1;
        wait_cpu(2);
        f0 = int'(cpu_r[CPU_N]);
        wait_cpu(5);
        chk("R7 free copy runs again", int'(cpu_r[CPU_N]) - f0, 5);
        wait_cpu(20);

        // R2: no runt or stretched pulse anywhere
        runts = 0;
        for (int j = 0; j <= CPU_N; j++)  runts += int'(cpu_rt[j]);
        for (int j = 0; j <= PCI_N; j++)  runts += int'(pci_rt[j]);
        for (int j = 0; j <= SDR_N; j++)  runts += int'(sdr_rt[j]);
        for (int j = 0; j <= APIC_N; j++) runts += int'(ref_rt[j]);
        chk("R2 all high pulses full width", runts, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule